// File: doc/BRIEF.md
# Thermal Clock Modulation Controller

This block throttles a processor core by producing a clock-enable that alternately gates the core clock off and on. Two sources can start throttling. The automatic source follows a temperature-trip input from a sensor comparator, but only while the automatic-mode enable is high. The on-demand source follows a small control register that software writes. The enable output feeds an external glitch-free clock gate, which lies outside this block.

Modulation runs on a fixed period of PERIOD core cycles. PERIOD is derived from the core clock frequency parameter, so that no single on or off interval is longer than the configured time limit. When the automatic source is hot, the duty is a fixed half on and half off. When only the on-demand source is active, the duty is set by a 3-bit code in eighths of the period. Each period starts with the on interval. After the trip input clears, a hysteresis timer keeps the automatic source hot for a while, which prevents rapid toggling. Mode and duty are sampled only at period boundaries, so no pulse is ever cut short.

Top module: `thermal_clkmod`

## Requirements
- R1: While reset is low and on the first cycle after it, `clk_en_o` is 1 and `throttle_active_o` is 0. Reset clears the control register and the hysteresis timer.
- R2: When no source is active, `clk_en_o` stays 1 on every cycle.
- R3: When `auto_en_i` and `temp_trip_i` are both 1, throttling starts at the next period boundary. Each period is then PERIOD/2 cycles with `clk_en_o`=1 followed by PERIOD/2 cycles with `clk_en_o`=0.
- R4: While `auto_en_i` is 0, `temp_trip_i` has no effect and `throttle_active_o` stays 0.
- R5: After `temp_trip_i` falls, with `auto_en_i` still 1, the automatic source stays hot for HYST_CYCLES more cycles. Throttling then ends at the next period boundary after that.
- R6: A write with `reg_wdata_i[4]`=1 enables on-demand throttling at the next period boundary, whatever the temperature. With duty code k = `reg_wdata_i[3:1]` in the range 1..7, each period gives k·PERIOD/8 cycles on, followed by the rest of the period off.
- R7: Duty code 000 is treated as code 100 (half the period on).
- R8: When both sources are active, the half-period automatic duty applies while the trip input is high or the hysteresis timer is running. Otherwise the on-demand duty applies.
- R9: `throttle_active_o` and the duty in use change only at a period boundary, that is, when the internal phase counter wraps to 0.
- R10: PERIOD = 8·floor((CLK_MHZ·MAX_NS/1000)/7). No run of equal `clk_en_o` values during throttling lasts longer than CLK_MHZ·MAX_NS/1000 cycles.
- R11: `reg_wdata_i[0]` is ignored. A write with bit 4 = 0 disables the on-demand source at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_trip_i | input | 1 | Die temperature near limit (comparator output) |
| auto_en_i | input | 1 | Enables temperature-driven throttling |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 5 | Write data: bit 4 on-demand enable, bits 3:1 duty code, bit 0 unused |
| clk_en_o | output | 1 | Core clock enable for the external gate |
| throttle_active_o | output | 1 | Modulation in progress |

## Verification
The hard case is when the automatic source and the on-demand source are both active in the same cycle. The bench sets up an on-demand duty of 2/8 and then raises the trip input with automatic mode enabled. It measures a half-period on-time while the trip is high, and again while the hysteresis timer runs down. After the timer expires, it measures the 2/8 on-time again. A register write that lands mid-period is also placed against the boundary. The bench checks that the active flag does not move until the phase counter wraps. A behavioural model compares both outputs on every cycle.

// File: rtl/thermal_clkmod_pkg.sv
package thermal_clkmod_pkg;

  typedef struct packed {
    logic       active;
    logic [2:0] units;
  } mod_req_t;

  function automatic int calc_max_run(input int clk_mhz, input int max_ns);
    return (clk_mhz * max_ns) / 1000;
  endfunction

  function automatic int calc_period(input int clk_mhz, input int max_ns);
    return 8 * (calc_max_run(clk_mhz, max_ns) / 7);
  endfunction

endpackage

// File: rtl/thermal_ctrl_reg.sv
module thermal_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [4:0] wdata_i,
  output logic       od_en_o,
  output logic [2:0] duty_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_en_o <= 1'b0;
      duty_o  <= 3'd0;
    end else if (wr_i) begin
      od_en_o <= wdata_i[4];
      duty_o  <= wdata_i[3:1];
    end
  end
endmodule

// File: rtl/thermal_hyst_timer.sv
module thermal_hyst_timer #(
  parameter int HYST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en_i,
  input  logic trip_i,
  output logic hot_o
);
  localparam int HW = $clog2(HYST_CYCLES + 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!auto_en_i)     cnt_q <= '0;
    else if (trip_i)         cnt_q <= HW'(HYST_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign hot_o = auto_en_i & (trip_i | (cnt_q != '0));
endmodule

// File: rtl/thermal_mod_gen.sv
module thermal_mod_gen
  import thermal_clkmod_pkg::*;
#(
  parameter int PERIOD = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  mod_req_t                     req_i,
  output logic                         clk_en_o,
  output logic                         active_o,
  output logic [$clog2(PERIOD)-1:0]    phase_o
);
  localparam int PW   = $clog2(PERIOD);
  localparam int UNIT = PERIOD / 8;

  logic [PW-1:0] phase_q;
  logic          act_q;
  logic [2:0]    units_q;
  logic [PW:0]   thr [8];

  for (genvar g = 0; g < 8; g++) begin : g_thr
    assign thr[g] = (PW+1)'(g * UNIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      act_q   <= 1'b0;
      units_q <= 3'd4;
    end else if (phase_q == PW'(PERIOD - 1)) begin
      phase_q <= '0;
      act_q   <= req_i.active;
      units_q <= req_i.units;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign clk_en_o = ~act_q | ({1'b0, phase_q} < thr[units_q]);
  assign active_o = act_q;
  assign phase_o  = phase_q;
endmodule

// File: rtl/thermal_clkmod.sv
module thermal_clkmod
  import thermal_clkmod_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int MAX_NS      = 3000,
  parameter int HYST_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       temp_trip_i,
  input  logic       auto_en_i,
  input  logic       reg_wr_i,
  input  logic [4:0] reg_wdata_i,
  output logic       clk_en_o,
  output logic       throttle_active_o
);
  localparam int MAX_RUN = calc_max_run(CLK_MHZ, MAX_NS);
  localparam int PERIOD  = calc_period(CLK_MHZ, MAX_NS);
  localparam int PW      = $clog2(PERIOD);

  logic          od_en;
  logic [2:0]    duty;
  logic          auto_hot;
  mod_req_t      req;
  logic [PW-1:0] phase;

  thermal_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .od_en_o(od_en), .duty_o(duty)
  );

  thermal_hyst_timer #(.HYST_CYCLES(HYST_CYCLES)) u_hyst (
    .clk(clk), .rst_n(rst_n), .auto_en_i(auto_en_i), .trip_i(temp_trip_i),
    .hot_o(auto_hot)
  );

  always_comb begin
    req.active = auto_hot | od_en;
    if (auto_hot || duty == 3'd0) req.units = 3'd4;
    else                          req.units = duty;
  end

  thermal_mod_gen #(.PERIOD(PERIOD)) u_gen (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .clk_en_o(clk_en_o), .active_o(throttle_active_o), .phase_o(phase)
  );
endmodule

// File: rtl/thermal_clkmod_chk.sv
module thermal_clkmod_chk #(
  parameter int PERIOD  = 24,
  parameter int MAX_RUN = 24,
  parameter int PW      = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_en_i,
  input logic          temp_trip_i,
  input logic          clk_en_o,
  input logic          throttle_active_o,
  input logic [PW-1:0] phase
);
  logic [15:0] run_q;
  logic        prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 16'd0;
      prev_q <= 1'b1;
    end else begin
      prev_q <= clk_en_o;
      if (!throttle_active_o)      run_q <= 16'd0;
      else if (clk_en_o != prev_q) run_q <= 16'd1;
      else                         run_q <= run_q + 16'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_OUTPUTS: assert (clk_en_o && !throttle_active_o); // R1
  end

  AST_IDLE_ENABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !throttle_active_o |-> clk_en_o); // R2

  AST_AUTO_STARTS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PW'(PERIOD - 1) && auto_en_i && temp_trip_i) |=> throttle_active_o); // R3

  AST_CHANGE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(throttle_active_o) |-> phase == '0); // R9

  AST_RUN_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 16'(MAX_RUN)); // R10
endmodule

bind thermal_clkmod thermal_clkmod_chk #(.PERIOD(PERIOD), .MAX_RUN(MAX_RUN), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_en_i(auto_en_i), .temp_trip_i(temp_trip_i),
  .clk_en_o(clk_en_o), .throttle_active_o(throttle_active_o), .phase(phase)
);

// File: tb/thermal_clkmod_test.sv
module thermal_clkmod_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 8;
  localparam int MAX_NS     = 3000;
  localparam int HYST       = 40;
  localparam int MAX_RUN    = CLK_MHZ * MAX_NS / 1000;
  localparam int REF_P      = 8 * (MAX_RUN / 7);
  localparam int UNIT       = REF_P / 8;

  logic clk = 1'b0, rst_n = 1'b0, trip = 1'b0, auto_en = 1'b0, wr = 1'b0;
  logic [4:0] wdata = 5'd0;
  logic clk_en_o, throttle_active_o;

  int checks = 0, failures = 0;
  string cur_tag = "R1";
  bit run_cmp = 1'b0;

  int m_ph = 0, m_units = 4, m_hyst = 0, m_dut = 0;
  bit m_act = 0, m_od = 0;
  int longest = 0, cur_run = 0;
  bit prev_en = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_clkmod #(.CLK_MHZ(CLK_MHZ), .MAX_NS(MAX_NS), .HYST_CYCLES(HYST)) uut (
    .clk(clk), .rst_n(rst_n), .temp_trip_i(trip), .auto_en_i(auto_en),
    .reg_wr_i(wr), .reg_wdata_i(wdata),
    .clk_en_o(clk_en_o), .throttle_active_o(throttle_active_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_units = 4; m_hyst = 0; m_dut = 0; m_act = 0; m_od = 0;
    end else begin
      bit hot;
      hot = auto_en && (trip || m_hyst > 0);
      if (m_ph == REF_P - 1) begin
        m_act = hot || m_od;
        m_units = (hot || m_dut == 0) ? 4 : m_dut;
        m_ph = 0;
      end else m_ph++;
      if (!auto_en) m_hyst = 0;
      else if (trip) m_hyst = HYST;
      else if (m_hyst > 0) m_hyst--;
      if (wr) begin m_od = wdata[4]; m_dut = int'(wdata[3:1]); end
    end
  end

  function automatic bit ref_en();
    return !m_act || (m_ph < m_units * UNIT);
  endfunction

  always @(negedge clk) begin
    if (run_cmp) begin
      check(clk_en_o == ref_en(), {cur_tag, " clk_en per-cycle"}, clk_en_o, ref_en());
      check(throttle_active_o == m_act, {cur_tag, " active per-cycle"}, throttle_active_o, m_act);
    end
    if (throttle_active_o) begin
      if (clk_en_o == prev_en) cur_run++; else cur_run = 1;
      if (cur_run > longest) longest = cur_run;
    end else cur_run = 0;
    prev_en = clk_en_o;
  end

  task automatic write(input logic [4:0] d);
    wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic measure(input int exp_on, input bit exp_act, input string tag);
    int on = 0, act_n = 0;
    @(negedge clk); @(negedge clk);
    while (m_ph != 0) @(negedge clk);
    for (int i = 0; i < REF_P; i++) begin
      if (clk_en_o) on++;
      if (throttle_active_o) act_n++;
      @(negedge clk);
    end
    check(on == exp_on, {tag, " on-cycles per period"}, on, exp_on);
    check(act_n == (exp_act ? REF_P : 0), {tag, " active cycles"}, act_n, exp_act ? REF_P : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit seen;
    repeat (4) @(negedge clk);
    check(clk_en_o == 1'b1, "R1 clk_en in reset", clk_en_o, 1);
    check(throttle_active_o == 1'b0, "R1 active in reset", throttle_active_o, 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(negedge clk);
    check(clk_en_o && !throttle_active_o, "R1 first cycle after reset", clk_en_o, 1);

    cur_tag = "R2";
    measure(REF_P, 0, "R2 idle");

    cur_tag = "R4"; trip = 1'b1; seen = 0;
    for (int i = 0; i < 3 * REF_P; i++) begin
      if (throttle_active_o) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R4 trip without auto enable", seen, 0);

    cur_tag = "R3"; auto_en = 1'b1;
    measure(REF_P / 2, 1, "R3 automatic");

    cur_tag = "R5"; trip = 1'b0;
    repeat (HYST / 2) @(negedge clk);
    check(throttle_active_o == 1'b1, "R5 held during hysteresis", throttle_active_o, 1);
    repeat (HYST + REF_P + 2) @(negedge clk);
    check(throttle_active_o == 1'b0, "R5 released after hysteresis", throttle_active_o, 0);
    auto_en = 1'b0;

    cur_tag = "R6";
    for (int k = 1; k < 8; k++) begin
      write({1'b1, 3'(k), 1'b0});
      measure(k * UNIT, 1, $sformatf("R6 code %0d", k));
    end
    cur_tag = "R11";
    write(5'b1_011_1);
    measure(3 * UNIT, 1, "R11 bit0 ignored");
    cur_tag = "R7";
    write(5'b1_000_0);
    measure(4 * UNIT, 1, "R7 code 000");

    cur_tag = "R8";
    write(5'b1_010_0);
    measure(2 * UNIT, 1, "R8 on-demand alone");
    auto_en = 1'b1; trip = 1'b1;
    measure(REF_P / 2, 1, "R8 trip overrides");
    trip = 1'b0;
    measure(REF_P / 2, 1, "R8 hysteresis overrides");
    repeat (HYST + REF_P) @(negedge clk);
    measure(2 * UNIT, 1, "R8 on-demand resumes");
    auto_en = 1'b0;

    cur_tag = "R11";
    write(5'b0_101_0);
    measure(REF_P, 0, "R11 disable write");

    cur_tag = "R9";
    while (m_ph != 5) @(negedge clk);
    write(5'b1_110_0);
    check(throttle_active_o == 1'b0, "R9 no change mid-period", throttle_active_o, 0);
    while (m_ph != 0) @(negedge clk);
    check(throttle_active_o == 1'b1, "R9 change at wrap", throttle_active_o, 1);
    write(5'b1_001_0);
    measure(UNIT, 1, "R9 code 1");

    cur_tag = "R10";
    check(REF_P == 24, "R10 period from frequency", REF_P, 24);
    check(longest <= MAX_RUN, "R10 longest interval", longest, MAX_RUN);
    check(longest == 7 * UNIT, "R10 longest seen is 7/8 period", longest, 7 * UNIT);

    run_cmp = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule